// File: doc/BRIEF.md
# Four-Lane Coefficient-Bank Multiply-Accumulate Datapath

This block is the arithmetic core of a small image or signal filter. Four signed 12-bit samples arrive on four independent lanes. A shared 8-bit row index picks one set of four 12-bit coefficients, one coefficient per lane, out of four 256-deep coefficient memories. Each lane multiplies its sample by its coefficient. An adder tree of two stages reduces the four products to one sum. A 32-bit accumulator then either restarts from that sum or adds it to its running total.

The lane registers and the row register each have an active-low load enable. This lets a sequencer keep some samples steady while others change, or hold one coefficient set across many cycles. A mode bit travels down the pipeline next to its data and chooses between restart and accumulate. A write port loads one complete coefficient set, all four lanes, in a single cycle. All storage sits behind registers, so each coefficient memory maps onto one block RAM with a registered read.

Top module: `mac4_filter_core`

## Requirements
- R1: A synchronous active-high `rst` clears every pipeline register and the accumulator. `acc_out` then reads 0 until data captured after reset reaches the output.
- R2: Lane i takes its sample from `din[12*i+11:12*i]`. It loads on a rising edge only while `din_en_n[i]` is 0. While that bit is 1 the lane keeps its previous sample.
- R3: The row register loads `row_addr` on a rising edge only while `row_en_n` is 0, and otherwise holds. A row value N selects coefficient set N in all four memories.
- R4: Data, row and mode captured at edge E show up in `acc_out` just after edge E+5. The coefficients of a newly registered row are read on the edge that follows the row capture.
- R5: Each lane forms the full signed 24-bit product of two two's-complement 12-bit operands. The four products are added in two stages and sign-extended to 32 bits.
- R6: The mode captured with a sample set controls that set's accumulation. A mode of 0 makes `acc_out` equal that set's sum alone. A mode of 1 makes it the previous `acc_out` plus that sum.
- R7: Accumulation wraps modulo 2^32 and gives no overflow indication.
- R8: While `wr_en` is 1, one edge writes `wr_coef[12*i+11:12*i]` into memory i at index `wr_set`. A read of that same index on the same edge returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 48 | Four packed signed samples, lane 0 in the low bits |
| din_en_n | input | 4 | Per-lane sample load enable, active low |
| row_addr | input | 8 | Coefficient set index |
| row_en_n | input | 1 | Row register load enable, active low |
| acc_mode | input | 1 | 0 restarts the total, 1 adds to it |
| wr_en | input | 1 | Coefficient set write strobe |
| wr_set | input | 8 | Coefficient set index to write |
| wr_coef | input | 48 | Four packed coefficients, lane 0 in the low bits |
| acc_out | output | 32 | Accumulated result |

## Verification
The bench builds the block with its default parameters: 12-bit samples and coefficients, 8-bit set index and 32-bit accumulator. With these values the extreme operand -2048 applies on every lane. Set 255, the top of the index range, is reachable. The largest possible sum per cycle is 2^24, so a run of 256 accumulating cycles wraps the 32-bit total, and that wrap completes inside the bench's run time.

// File: rtl/mac4_pkg.sv
package mac4_pkg;
  localparam int MAC_LANES = 4;
  localparam int ACC_DELAY = 5;

  typedef enum logic {
    MODE_RESTART = 1'b0,
    MODE_ACCUM   = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/mac4_coef_bank.sv
module mac4_coef_bank #(
  parameter int COEF_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [COEF_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [COEF_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [COEF_W-1:0] mem [DEPTH];

  // Read-first single clock memory: the read sees contents before a same-edge write.
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mac4_lane.sv
module mac4_lane #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int PROD_W = DATA_W + COEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        din,
  input  logic                     load_n,
  input  logic [COEF_W-1:0]        coef,
  output logic [DATA_W-1:0]        sample_q,
  output logic signed [PROD_W-1:0] prod_q
);
  logic [DATA_W-1:0] sample_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_q <= '0;
      sample_d <= '0;
      prod_q   <= '0;
    end else begin
      if (!load_n) begin
        sample_q <= din;
      end
      sample_d <= sample_q;
      prod_q   <= $signed(sample_d) * $signed(coef);
    end
  end
endmodule

// File: rtl/mac4_sum_acc.sv
module mac4_sum_acc #(
  parameter int PROD_W = 24,
  parameter int ACC_W  = 32,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*PROD_W-1:0] prods,
  input  logic                    mode_al,
  output logic [ACC_W-1:0]        sum_q,
  output logic [ACC_W-1:0]        acc_q
);
  localparam int PAIRS = LANES / 2;
  localparam int PAIR_W = PROD_W + 1;
  localparam int TOT_W = PROD_W + 2;

  logic signed [PAIR_W-1:0] pair_q [PAIRS];
  logic signed [TOT_W-1:0]  tot_q;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst) begin
        pair_q[k] <= '0;
      end else begin
        pair_q[k] <= $signed(prods[(2*k)*PROD_W +: PROD_W])
                   + $signed(prods[(2*k+1)*PROD_W +: PROD_W]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_q <= '0;
    end else begin
      tot_q <= pair_q[0] + pair_q[1];
    end
  end

  assign sum_q = {{(ACC_W-TOT_W){tot_q[TOT_W-1]}}, tot_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (mode_al == mac4_pkg::MODE_ACCUM) begin
      acc_q <= acc_q + sum_q;
    end else begin
      acc_q <= sum_q;
    end
  end
endmodule

// File: rtl/mac4_filter_core.sv
module mac4_filter_core #(
  parameter int DATA_W = 12,
  parameter int COEF_W = 12,
  parameter int ADDR_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic [mac4_pkg::MAC_LANES*DATA_W-1:0] din,
  input  logic [mac4_pkg::MAC_LANES-1:0]        din_en_n,
  input  logic [ADDR_W-1:0]                     row_addr,
  input  logic                                  row_en_n,
  input  logic                                  acc_mode,
  input  logic                                  wr_en,
  input  logic [ADDR_W-1:0]                     wr_set,
  input  logic [mac4_pkg::MAC_LANES*COEF_W-1:0] wr_coef,
  output logic [ACC_W-1:0]                      acc_out
);
  localparam int LANES = mac4_pkg::MAC_LANES;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int DLY = mac4_pkg::ACC_DELAY;

  logic [ADDR_W-1:0]       row_q;
  logic [LANES*DATA_W-1:0] lane_q;
  logic [LANES*PROD_W-1:0] prods;
  logic [DLY-1:0]          mode_sr;
  logic                    mode_al;
  logic [ACC_W-1:0]        sum_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
    end else if (!row_en_n) begin
      row_q <= row_addr;
    end
  end

  // Mode travels with its data: one stage per pipeline register before the accumulator.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_sr <= '0;
    end else begin
      mode_sr <= {mode_sr[DLY-2:0], acc_mode};
    end
  end
  assign mode_al = mode_sr[DLY-1];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [COEF_W-1:0]        coef;
    logic signed [PROD_W-1:0] prod;

    mac4_coef_bank #(
      .COEF_W(COEF_W),
      .ADDR_W(ADDR_W)
    ) u_bank (
      .clk  (clk),
      .we   (wr_en),
      .waddr(wr_set),
      .wdata(wr_coef[i*COEF_W +: COEF_W]),
      .raddr(row_q),
      .rdata(coef)
    );

    mac4_lane #(
      .DATA_W(DATA_W),
      .COEF_W(COEF_W),
      .PROD_W(PROD_W)
    ) u_lane (
      .clk     (clk),
      .rst     (rst),
      .din     (din[i*DATA_W +: DATA_W]),
      .load_n  (din_en_n[i]),
      .coef    (coef),
      .sample_q(lane_q[i*DATA_W +: DATA_W]),
      .prod_q  (prod)
    );

    assign prods[i*PROD_W +: PROD_W] = prod;
  end

  mac4_sum_acc #(
    .PROD_W(PROD_W),
    .ACC_W (ACC_W),
    .LANES (LANES)
  ) u_sum (
    .clk    (clk),
    .rst    (rst),
    .prods  (prods),
    .mode_al(mode_al),
    .sum_q  (sum_q),
    .acc_q  (acc_out)
  );
endmodule

// File: rtl/mac4_filter_core_chk.sv
module mac4_filter_core_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8,
  parameter int ACC_W  = 32,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES*DATA_W-1:0] din,
  input logic [LANES-1:0]        din_en_n,
  input logic [ADDR_W-1:0]       row_addr,
  input logic                    row_en_n,
  input logic [ADDR_W-1:0]       row_q,
  input logic [LANES*DATA_W-1:0] lane_q,
  input logic                    mode_al,
  input logic [ACC_W-1:0]        sum_q,
  input logic [ACC_W-1:0]        acc_out
);
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> acc_out == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    a_r2_lane_hold: assert property (@(posedge clk) disable iff (rst)
      din_en_n[i] |=> $stable(lane_q[i*DATA_W +: DATA_W]));
    a_r2_lane_load: assert property (@(posedge clk) disable iff (rst)
      !din_en_n[i] |=> lane_q[i*DATA_W +: DATA_W] == $past(din[i*DATA_W +: DATA_W]));
  end

  a_r3_row_hold: assert property (@(posedge clk) disable iff (rst)
    row_en_n |=> $stable(row_q));
  a_r3_row_load: assert property (@(posedge clk) disable iff (rst)
    !row_en_n |=> row_q == $past(row_addr));

  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    !mode_al |=> acc_out == $past(sum_q));
  a_r6_accumulate: assert property (@(posedge clk) disable iff (rst)
    mode_al |=> acc_out == $past(acc_out) + $past(sum_q));
endmodule

bind mac4_filter_core mac4_filter_core_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W),
  .ACC_W (ACC_W),
  .LANES (mac4_pkg::MAC_LANES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .din_en_n(din_en_n),
  .row_addr(row_addr),
  .row_en_n(row_en_n),
  .row_q   (row_q),
  .lane_q  (lane_q),
  .mode_al (mode_al),
  .sum_q   (sum_q),
  .acc_out (acc_out)
);

// File: tb/mac4_filter_core_test.sv
module mac4_filter_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int HIST = 1024;

  typedef struct packed {
    logic [47:0] d;
    logic [7:0]  row;
    logic        mode;
  } tv_t;

  // Stimulus vectors: samples (lane3..lane0), row, mode; results come from the bench model.
  localparam tv_t TBL [12] = '{
    '{48'h001_002_003_004, 8'd0,   1'b0},
    '{48'hFFF_FFF_FFF_FFF, 8'd0,   1'b0},
    '{48'h800_7FF_800_7FF, 8'd1,   1'b0},
    '{48'h010_020_030_040, 8'd1,   1'b1},
    '{48'h7FF_7FF_7FF_7FF, 8'd2,   1'b1},
    '{48'h800_800_800_800, 8'd2,   1'b1},
    '{48'h123_000_456_000, 8'd255, 1'b0},
    '{48'h000_000_000_001, 8'd255, 1'b1},
    '{48'hABC_DEF_012_345, 8'd1,   1'b1},
    '{48'h000_000_000_000, 8'd0,   1'b0},
    '{48'h555_AAA_555_AAA, 8'd2,   1'b0},
    '{48'h7FF_800_001_FFF, 8'd1,   1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] din = '0;
  logic [3:0]  din_en_n = 4'hF;
  logic [7:0]  row_addr = '0;
  logic        row_en_n = 1'b1;
  logic        acc_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_set = '0;
  logic [47:0] wr_coef = '0;
  logic [31:0] acc_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic signed [11:0] cm [256][4];
  logic signed [11:0] dm [4];
  logic [7:0]         rm;
  logic [31:0]        am;
  logic [31:0]        hist [HIST];
  string              htag [HIST];
  int                 n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac4_filter_core uut (
    .clk     (clk),
    .rst     (rst),
    .din     (din),
    .din_en_n(din_en_n),
    .row_addr(row_addr),
    .row_en_n(row_en_n),
    .acc_mode(acc_mode),
    .wr_en   (wr_en),
    .wr_set  (wr_set),
    .wr_coef (wr_coef),
    .acc_out (acc_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: acc_out=%h expected=%h (step %0d)", tag, got, exp, n);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) dm[i] = '0;
    rm = '0;
    am = '0;
    n = 0;
  endtask

  // One clock step: check the output due now, then drive the next inputs and model them.
  task automatic step(input logic [47:0] d, input logic [3:0] den_n, input logic [7:0] row,
                      input logic ren_n, input logic mode, input logic we,
                      input logic [7:0] wset, input logic [47:0] wc, input string tag);
    int s;
    @(negedge clk);
    if (n >= 6) check(htag[(n-6) % HIST], acc_out, hist[(n-6) % HIST]);
    else        check("R1", acc_out, 32'h0);
    din = d; din_en_n = den_n; row_addr = row; row_en_n = ren_n;
    acc_mode = mode; wr_en = we; wr_set = wset; wr_coef = wc;
    if (we) for (int i = 0; i < 4; i++) cm[wset][i] = wc[i*12 +: 12];
    for (int i = 0; i < 4; i++) if (!den_n[i]) dm[i] = d[i*12 +: 12];
    if (!ren_n) rm = row;
    s = 0;
    for (int i = 0; i < 4; i++) s = s + int'(dm[i]) * int'(cm[rm][i]);
    am = mode ? am + 32'(s) : 32'(s);
    hist[n % HIST] = am;
    htag[n % HIST] = tag;
    n++;
  endtask

  task automatic idle(input string tag);
    step(48'h0, 4'hF, 8'h0, 1'b1, 1'b0, 1'b0, 8'h0, 48'h0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; din_en_n = 4'hF; row_en_n = 1'b1; acc_mode = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  initial begin
    for (int s = 0; s < 256; s++) for (int i = 0; i < 4; i++) cm[s][i] = '0;
    model_reset();
    do_reset();
    // R1: reset state while coefficient sets are loaded (R8)
    step(48'h0, 4'hF, 8'h0, 1'b1, 1'b0, 1'b1, 8'd0,   48'h001_002_003_004, "R8");
    step(48'h0, 4'hF, 8'h0, 1'b1, 1'b0, 1'b1, 8'd1,   48'h7FF_800_FFF_001, "R8");
    step(48'h0, 4'hF, 8'h0, 1'b1, 1'b0, 1'b1, 8'd2,   48'h123_456_789_ABC, "R8");
    step(48'h0, 4'hF, 8'h0, 1'b1, 1'b0, 1'b1, 8'd255, 48'h800_800_800_800, "R8");
    // Table walk: signed products, sums and mode handling (R5, R6, R4)
    foreach (TBL[k]) begin
      step(TBL[k].d, 4'h0, TBL[k].row, 1'b0, TBL[k].mode, 1'b0, 8'h0, 48'h0,
           TBL[k].mode ? "R6" : "R5");
    end
    // R4: single impulse after idle cycles
    repeat (6) idle("R4");
    step(48'h000_000_000_003, 4'h0, 8'd0, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R4");
    repeat (6) idle("R4");
    // R2: lanes 1 and 3 hold while 0 and 2 load
    step(48'h005_005_005_005, 4'h0, 8'd2, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R2");
    step(48'h111_222_333_444, 4'b1010, 8'd2, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R2");
    step(48'h7FF_7FF_7FF_7FF, 4'b0101, 8'd2, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R2");
    // R3: row held although row_addr changes
    step(48'h001_001_001_001, 4'h0, 8'd1, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R3");
    step(48'h001_001_001_001, 4'h0, 8'd0, 1'b1, 1'b0, 1'b0, 8'h0, 48'h0, "R3");
    step(48'h001_001_001_001, 4'h0, 8'd2, 1'b1, 1'b0, 1'b0, 8'h0, 48'h0, "R3");
    // R8: write to the set being read; the earlier read sees old values
    step(48'h001_001_001_001, 4'h0, 8'd2, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R8");
    step(48'h001_001_001_001, 4'h0, 8'd2, 1'b1, 1'b0, 1'b1, 8'd2, 48'h010_020_030_040, "R8");
    step(48'h001_001_001_001, 4'h0, 8'd2, 1'b1, 1'b0, 1'b0, 8'h0, 48'h0, "R8");
    repeat (6) idle("R8");
    // R7: 256+ max-magnitude accumulations wrap the total
    step(48'h800_800_800_800, 4'h0, 8'd255, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R7");
    for (int k = 0; k < 300; k++)
      step(48'h800_800_800_800, 4'h0, 8'd255, 1'b0, 1'b1, 1'b0, 8'h0, 48'h0, "R7");
    repeat (6) idle("R7");
    // R1: reset in the middle of activity
    step(48'h7FF_7FF_7FF_7FF, 4'h0, 8'd1, 1'b0, 1'b1, 1'b0, 8'h0, 48'h0, "R1");
    do_reset();
    repeat (6) idle("R1");
    step(48'h002_002_002_002, 4'h0, 8'd0, 1'b0, 1'b0, 1'b0, 8'h0, 48'h0, "R1");
    repeat (6) idle("R1");
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule